// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits behind the write side of a flash device's host port and interprets the words written into the boot-buffer address window as commands. Only two address ranges count as command ports: word offsets 0x0000–0x01FF and 0x8000–0x800F. Writes that land anywhere else pass it by. The block supports a two-write page-load protocol, a warm reset, and an identification fill. Unrecognised values raise a one-cycle flag.

For a page load, the block issues a one-cycle request that carries the current start block and the page start address. The page transfer itself belongs to a neighbouring engine. After each load the block advances its page start-address register by four, wrapping within 8 bits. The identification command writes the low bytes of three identity words into the first words of a small buffer RAM model. The host can read that RAM back through a read port.

Top module: `bootWindowSeq`

## Requirements
- R1: A write is decoded only when `wrAddr` lies in 0x0000–0x01FF or 0x8000–0x800F. Any other write leaves every output and all internal state unchanged.
- R2: An in-window write of 0x00E0 arms a load. If the next in-window write carries 0x0000, `loadReq` goes high for exactly the one cycle after that write, with `loadBlock` equal to `blockAddr` and `loadPage` equal to the page start address held before the write.
- R3: The load of R2 sets the page start address to (old value + 4) modulo 256, with bits 15:8 equal to zero.
- R4: The in-window write that follows an armed state always disarms it, whatever its data. That write is never decoded as a command, so 0x00F0, 0x0090 or any other value there produces no pulse and no buffer or page change.
- R5: An unarmed in-window write of 0x0090 sets buffer words 0, 1 and 2 to {8'h00, `mfrId`[7:0]}, {8'h00, `devId`[7:0]} and {8'h00, `wpStatus`[7:0]}. The values are visible on `rdData` from the cycle after the write.
- R6: An unarmed in-window write of 0x00F0 pulses `warmRst` for one cycle after the write, clears the page start address to 0 and leaves the block unarmed.
- R7: An unarmed in-window write of any value other than 0x00E0, 0x0090 or 0x00F0 (0x0000 included) pulses `unknownCmd` for one cycle and changes no other state. At most one of `loadReq`, `warmRst` and `unknownCmd` is high in any cycle.
- R8: After reset the page start address is 0, every buffer word reads 0, all pulses are low and the block is unarmed. A cycle with `pageSetEn` high loads `pageSetVal` into the page start address.
- R9: Writes outside the command windows between the arming write and the next in-window write do not disarm the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 16 | Host write word offset |
| wrData | input | 16 | Host write data |
| blockAddr | input | 16 | Current start block address |
| pageSetEn | input | 1 | Load the page start address from `pageSetVal` |
| pageSetVal | input | 16 | New page start address |
| mfrId | input | 16 | Manufacturer identity word |
| devId | input | 16 | Device identity word |
| wpStatus | input | 16 | Write-protection status word |
| rdAddr | input | 4 | Buffer RAM read word address |
| rdData | output | 16 | Buffer RAM read data |
| pageAddr | output | 16 | Current page start address |
| loadReq | output | 1 | One-cycle page-load request |
| loadBlock | output | 16 | Block address of the load request |
| loadPage | output | 16 | Page address of the load request |
| warmRst | output | 1 | One-cycle warm-reset pulse |
| unknownCmd | output | 1 | One-cycle unknown-command pulse |

## Verification
The embedded properties watch, on every cycle, several cycle-level facts. The write after an armed state clears the arm. Out-of-window writes leave the arm alone. The three event pulses never overlap and each lasts one cycle. Every load steps the page address by four within 8 bits and reports the pre-increment page. The bench scenarios are needed for the behaviours that depend on sequences of writes and on data values: the arm surviving stray writes, a trailing 0x00F0 that is swallowed instead of resetting, a window edge at 0x01FF versus 0x0200, and the exact identity bytes in the buffer.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] CMD_ARM_LOAD = 16'h00E0;
  localparam logic [WORD_W-1:0] CMD_IDENT    = 16'h0090;
  localparam logic [WORD_W-1:0] CMD_WARM     = 16'h00F0;
  localparam logic [WORD_W-1:0] LOAD_GO      = 16'h0000;

  // Strobes from the control decoder to the datapath, valid for one cycle.
  typedef struct packed {
    logic arm;
    logic load;
    logic ident;
    logic warm;
    logic unknown;
  } seqStrobes_t;

endpackage

// File: rtl/bootSeqCtrl.sv
module bootSeqCtrl
  import bootseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOW_LAST   = 16'h01FF,
  parameter logic [ADDR_W-1:0] HIGH_FIRST = 16'h8000,
  parameter logic [ADDR_W-1:0] HIGH_LAST  = 16'h800F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output seqStrobes_t       strobes
);

  logic armed;
  logic inLowWin;
  logic inHighWin;
  logic winWr;

  // The low window starts at offset zero, so only its upper bound matters.
  assign inLowWin  = (wrAddr <= LOW_LAST);
  assign inHighWin = (wrAddr >= HIGH_FIRST) && (wrAddr <= HIGH_LAST);
  assign winWr     = wrEn && (inLowWin || inHighWin);

  always_comb begin
    strobes = '0;
    if (winWr) begin
      if (armed) begin
        // Second write of the load protocol: only a zero word triggers a load.
        strobes.load = (wrData == LOAD_GO);
      end else begin
        unique case (wrData)
          CMD_ARM_LOAD: strobes.arm     = 1'b1;
          CMD_IDENT:    strobes.ident   = 1'b1;
          CMD_WARM:     strobes.warm    = 1'b1;
          default:      strobes.unknown = 1'b1;
        endcase
      end
    end
  end

  // Armed state: set by the arming word, cleared by any following window write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (winWr) begin
      armed <= strobes.arm;
    end
  end

  AST_FOLLOWUP_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    armed && winWr |=> !armed); // R4

  AST_FOLLOWUP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !(strobes.warm || strobes.ident || strobes.unknown || strobes.arm)); // R4

  AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !(inLowWin || inHighWin) |=> $stable(armed)); // R9

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R7

endmodule

// File: rtl/bootSeqData.sv
module bootSeqData
  import bootseq_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int BUF_WORDS  = 16,
  parameter int PAGE_STEP  = 4,
  parameter int WRAP_BITS  = 8,
  parameter int ID_WORDS   = 3,
  localparam int BUFA_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [PAGE_W-1:0] blockAddr,
  input  logic              pageSetEn,
  input  logic [PAGE_W-1:0] pageSetVal,
  input  logic [WORD_W-1:0] mfrId,
  input  logic [WORD_W-1:0] devId,
  input  logic [WORD_W-1:0] wpStatus,
  input  logic [BUFA_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [PAGE_W-1:0] pageAddr,
  output logic              loadReq,
  output logic [PAGE_W-1:0] loadBlock,
  output logic [PAGE_W-1:0] loadPage,
  output logic              warmRst,
  output logic              unknownCmd
);

  localparam logic [PAGE_W-1:0] WRAP_MASK = PAGE_W'((1 << WRAP_BITS) - 1);
  localparam logic [PAGE_W-1:0] STEP_VAL  = PAGE_W'(PAGE_STEP);

  logic [PAGE_W-1:0] pageNext;
  logic [WORD_W-1:0] idWord [ID_WORDS];
  logic [WORD_W-1:0] bufMem [BUF_WORDS];

  assign pageNext = (pageAddr + STEP_VAL) & WRAP_MASK;

  // Page start-address register: warm reset beats a load, a load beats a set.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageAddr <= '0;
    end else if (strobes.warm) begin
      pageAddr <= '0;
    end else if (strobes.load) begin
      pageAddr <= pageNext;
    end else if (pageSetEn) begin
      pageAddr <= pageSetVal;
    end
  end

  // Load request pulse with the addresses sampled before the increment.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReq    <= 1'b0;
      loadBlock  <= '0;
      loadPage   <= '0;
      warmRst    <= 1'b0;
      unknownCmd <= 1'b0;
    end else begin
      loadReq    <= strobes.load;
      warmRst    <= strobes.warm;
      unknownCmd <= strobes.unknown;
      if (strobes.load) begin
        loadBlock <= blockAddr;
        loadPage  <= pageAddr;
      end
    end
  end

  // Identification words: low byte of each source, upper byte cleared.
  assign idWord[0] = {8'h00, mfrId[7:0]};
  assign idWord[1] = {8'h00, devId[7:0]};
  assign idWord[2] = {8'h00, wpStatus[7:0]};

  genvar w;
  generate
    for (w = 0; w < BUF_WORDS; w++) begin : gBuf
      if (w < ID_WORDS) begin : gIdWord
        always_ff @(posedge clk) begin
          if (!rstN) begin
            bufMem[w] <= '0;
          end else if (strobes.ident) begin
            bufMem[w] <= idWord[w];
          end
        end
      end else begin : gPlainWord
        always_ff @(posedge clk) begin
          if (!rstN) begin
            bufMem[w] <= '0;
          end
        end
      end
    end
  endgenerate

  assign rdData = bufMem[rdAddr];

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> pageAddr == ((($past(pageAddr)) + STEP_VAL) & WRAP_MASK)); // R3

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> !loadReq); // R2

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> loadPage == $past(pageAddr) && loadBlock == $past(blockAddr)); // R2

  AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.warm |=> pageAddr == '0 && warmRst); // R6

  AST_IDENT_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ident |=> bufMem[0][15:8] == 8'h00 && bufMem[2][7:0] == $past(wpStatus[7:0])); // R5

endmodule

// File: rtl/bootWindowSeq.sv
module bootWindowSeq
  import bootseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic [15:0] wrData,
  input  logic [15:0] blockAddr,
  input  logic        pageSetEn,
  input  logic [15:0] pageSetVal,
  input  logic [15:0] mfrId,
  input  logic [15:0] devId,
  input  logic [15:0] wpStatus,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  output logic [15:0] pageAddr,
  output logic        loadReq,
  output logic [15:0] loadBlock,
  output logic [15:0] loadPage,
  output logic        warmRst,
  output logic        unknownCmd
);

  seqStrobes_t strobes;

  bootSeqCtrl #(
    .ADDR_W     (16),
    .LOW_LAST   (16'h01FF),
    .HIGH_FIRST (16'h8000),
    .HIGH_LAST  (16'h800F)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  bootSeqData #(
    .PAGE_W    (16),
    .BUF_WORDS (16),
    .PAGE_STEP (4),
    .WRAP_BITS (8),
    .ID_WORDS  (3)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .blockAddr  (blockAddr),
    .pageSetEn  (pageSetEn),
    .pageSetVal (pageSetVal),
    .mfrId      (mfrId),
    .devId      (devId),
    .wpStatus   (wpStatus),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .pageAddr   (pageAddr),
    .loadReq    (loadReq),
    .loadBlock  (loadBlock),
    .loadPage   (loadPage),
    .warmRst    (warmRst),
    .unknownCmd (unknownCmd)
  );

  AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadReq, warmRst, unknownCmd})); // R7

  AST_UNKNOWN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    unknownCmd |-> $stable(pageAddr)); // R7

endmodule

// File: tb/bootWindowSeq_tb.sv
module bootWindowSeq_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [15:0] wrAddr, wrData, blockAddr, pageSetVal, mfrId, devId, wpStatus;
  logic        pageSetEn;
  logic [3:0]  rdAddr;
  logic [15:0] rdData, pageAddr, loadBlock, loadPage;
  logic        loadReq, warmRst, unknownCmd;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  // Expected event: kind 0 = load, 1 = warm reset, 2 = unknown command.
  typedef struct {
    logic [1:0]  kind;
    logic [15:0] blk;
    logic [15:0] pg;
    logic [31:0] tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5ns clk = ~clk;

  bootWindowSeq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .blockAddr(blockAddr), .pageSetEn(pageSetEn), .pageSetVal(pageSetVal),
    .mfrId(mfrId), .devId(devId), .wpStatus(wpStatus), .rdAddr(rdAddr),
    .rdData(rdData), .pageAddr(pageAddr), .loadReq(loadReq),
    .loadBlock(loadBlock), .loadPage(loadPage), .warmRst(warmRst),
    .unknownCmd(unknownCmd)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void pushExp(input logic [1:0] kind, input logic [15:0] blk,
                                  input logic [15:0] pg, input logic [31:0] tag);
    expItem_t it;
    it.kind = kind; it.blk = blk; it.pg = pg; it.tag = tag;
    expQ.push_back(it);
  endfunction

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPage(input logic [15:0] v);
    @(negedge clk);
    pageSetEn = 1'b1; pageSetVal = v;
    @(negedge clk);
    pageSetEn = 1'b0;
  endtask

  task automatic checkWord(input logic [3:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1ns;
    checkEq("R5", "buffer word", rdData, exp);
  endtask

  // Monitor: each event pulse pops one expected item and is compared with it.
  always @(negedge clk) begin
    if (rstN === 1'b1 && (loadReq || warmRst || unknownCmd)) begin
      logic [1:0] actKind;
      actKind = loadReq ? 2'd0 : (warmRst ? 2'd1 : 2'd2);
      checkCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL R1 unexpected event: actual kind %0d expected none", actKind);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (actKind != it.kind) begin
          failCount++;
          $display("FAIL %s event kind: actual %0d expected %0d", it.tag, actKind, it.kind);
        end else if (it.kind == 2'd0 && (loadBlock !== it.blk || loadPage !== it.pg)) begin
          failCount++;
          $display("FAIL %s load address: actual %h/%h expected %h/%h",
                   it.tag, loadBlock, loadPage, it.blk, it.pg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; blockAddr = 16'h0123;
    pageSetEn = 1'b0; pageSetVal = '0; mfrId = 16'hABCD; devId = 16'h5A3C;
    wpStatus = 16'h0002; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1ns;
    // R8: reset state
    checkEq("R8", "reset page", pageAddr, 16'h0000);
    checkEq("R8", "reset pulses", {13'd0, loadReq, warmRst, unknownCmd}, 16'h0000);
    checkWord(4'd0, 16'h0000);

    // R8 / R2 / R3: basic load
    setPage(16'h0010);
    checkEq("R8", "page set", pageAddr, 16'h0010);
    busWrite(16'h0000, 16'h00E0);
    pushExp(2'd0, 16'h0123, 16'h0010, "R2");
    busWrite(16'h8005, 16'h0000);
    checkEq("R3", "page after load", pageAddr, 16'h0014);

    // R3: wrap within 8 bits
    setPage(16'h12FE);
    blockAddr = 16'h0456;
    busWrite(16'h0100, 16'h00E0);
    pushExp(2'd0, 16'h0456, 16'h12FE, "R3");
    busWrite(16'h0001, 16'h0000);
    checkEq("R3", "page wrap", pageAddr, 16'h0002);

    // R4: armed then a warm-reset word is swallowed, disarmed afterwards
    busWrite(16'h0000, 16'h00E0);
    busWrite(16'h0000, 16'h00F0);
    checkEq("R4", "page untouched", pageAddr, 16'h0002);
    pushExp(2'd2, 16'h0000, 16'h0000, "R4");
    busWrite(16'h0000, 16'h0000);

    // R5: identification fill
    busWrite(16'h800F, 16'h0090);
    checkWord(4'd0, 16'h00CD);
    checkWord(4'd1, 16'h003C);
    checkWord(4'd2, 16'h0002);
    checkWord(4'd3, 16'h0000);

    // R6: warm reset clears page
    setPage(16'h0040);
    pushExp(2'd1, 16'h0000, 16'h0000, "R6");
    busWrite(16'h01FF, 16'h00F0);
    checkEq("R6", "page cleared", pageAddr, 16'h0000);

    // R7: unknown command
    setPage(16'h0020);
    pushExp(2'd2, 16'h0000, 16'h0000, "R7");
    busWrite(16'h0003, 16'h1234);
    checkEq("R7", "page kept", pageAddr, 16'h0020);

    // R1: outside-window writes ignored
    busWrite(16'h0200, 16'h00F0);
    busWrite(16'h8010, 16'h00E0);
    busWrite(16'h7FFF, 16'h0090);
    checkEq("R1", "page kept", pageAddr, 16'h0020);
    pushExp(2'd2, 16'h0000, 16'h0000, "R1");
    busWrite(16'h0000, 16'h0000);

    // R9: arm survives out-of-window writes
    busWrite(16'h0100, 16'h00E0);
    busWrite(16'h4000, 16'h0000);
    busWrite(16'hF220, 16'h1111);
    pushExp(2'd0, 16'h0456, 16'h0020, "R9");
    busWrite(16'h800F, 16'h0000);
    checkEq("R9", "page after load", pageAddr, 16'h0024);

    repeat (3) @(negedge clk);
    checkEq("R1", "pending events", 16'(expQ.size()), 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule